// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent page translations. Each entry pairs a virtual page number tag with a physical page number and three access-right bits. A lookup presents a full virtual address and an access kind. One cycle later the block reports one of three results:

- a translation, which is the cached physical page number followed by the untouched page offset;
- a protection fault, when the entry exists but forbids the requested access;
- a miss, which tells the surrounding logic that a table walk is needed.

The walker then installs its result through the fill port, and later lookups of that page hit. A flush input drops every entry at once.

Every entry is compared in parallel. When the block must choose an entry to replace, it takes an empty entry first and otherwise the least recently used one. Recency is kept as one age counter per entry. A lookup hit and a fill both make the entry they use the youngest.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is empty, so any lookup misses, and `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_paddr` are all zero.
- R2: The cycle after `lk_valid` is high, `rsp_valid` is high. On a permitted hit, `rsp_paddr` is the stored physical page number concatenated above the low `OFF_W` bits of `lk_vaddr`. `rsp_valid` is low the cycle after `lk_valid` is low.
- R3: If no valid entry's tag equals the upper bits of `lk_vaddr`, the response is a miss: `rsp_valid`=1, `rsp_hit`=0, `rsp_fault`=0.
- R4: The `fill_perm` bits are bit0 read, bit1 write and bit2 execute. The `lk_acc` codes are 0 read, 1 write, 2 execute, and 3 checked as read. A hit whose matching right bit is 0 gives `rsp_fault`=1, `rsp_hit`=0 and a zero address. `rsp_hit` and `rsp_fault` are never high together.
- R5: A fill is visible to lookups from the next cycle on. A lookup made in the same cycle as a fill sees the contents from before that fill.
- R6: A fill whose tag is already held overwrites that entry's page number and rights in place. No second copy is made, so no other entry is lost.
- R7: While any entry is empty, a fill goes into an empty entry (the lowest-numbered one), so N distinct fills after a flush all stay resident.
- R8: When all entries are full, a fill of a new tag replaces the least recently used entry. Lookup hits, including faulting hits, and fills each make their entry the most recently used. When a fill and a lookup hit fall in the same cycle, only the fill updates recency.
- R9: `flush` empties every entry in one cycle, and a fill given in the same cycle is dropped. A lookup in the flush cycle still sees the old contents.
- R10: `rsp_paddr` is zero whenever `rsp_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Permitted translation |
| rsp_fault | output | 1 | Entry found but access forbidden |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a permitted hit, else 0 |

## Verification
Two pairs of events can fall in the same cycle. The first is a lookup together with a fill of the same page. The bench issues both in one cycle and expects a miss, then a hit on the following lookup. The second is a flush together with a lookup or a fill. The bench expects the lookup in the flush cycle to hit on the old contents, and the page offered for fill in that cycle to miss afterwards. Recency ordering is judged through eviction order. After a faulting hit or a plain hit, the bench predicts which page a new fill displaces, then looks up both that page and its neighbours.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Access kinds presented on a lookup
  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  // Rights word: bit0 read, bit1 write, bit2 execute
  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } rights_t;

  function automatic logic rights_allow(input rights_t r, input logic [1:0] acc);
    case (acc_e'(acc))
      ACC_WR:  return r.wr;
      ACC_EX:  return r.ex;
      default: return r.rd;
    endcase
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  rights_t          wr_rights,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     lk_match,
  output logic [N-1:0]     fl_match,
  output logic [PPN_W-1:0] lk_ppn,
  output rights_t          lk_rights
);

  logic [VPN_W-1:0] tag_q    [N];
  logic [PPN_W-1:0] ppn_q    [N];
  rights_t          rights_q [N];
  logic [N-1:0]     vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // Payload needs no reset; it is qualified by the valid bits
  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) begin
      tag_q[wr_idx]    <= wr_vpn;
      ppn_q[wr_idx]    <= wr_ppn;
      rights_q[wr_idx] <= wr_rights;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    assign fl_match[g] = vld_q[g] && (tag_q[g] == fl_vpn);
  end

  // One-hot read mux; at most one entry can match
  always_comb begin
    lk_ppn    = '0;
    lk_rights = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_ppn    = lk_ppn | ppn_q[i];
        lk_rights = lk_rights | rights_q[i];
      end
    end
  end

  assign valid_vec = vld_q;

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch_en,
  input  logic [$clog2(N)-1:0] touch_idx,
  input  logic [N-1:0]         valid_vec,
  output logic [$clog2(N)-1:0] victim_idx,
  output logic [N-1:0]         oldest_vec
);

  localparam int IW = $clog2(N);

  // Ages always form a permutation of 0..N-1; 0 is the youngest
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) begin
          age_q[i] <= '0;
        end else if (age_q[i] < age_q[touch_idx]) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == IW'(N - 1));
  end

  logic [IW-1:0] vic_empty, vic_old;
  logic          any_empty;

  always_comb begin
    vic_empty = '0;
    any_empty = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        vic_empty = IW'(i);
        any_empty = 1'b1;
      end
    end
    vic_old = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest_vec[i]) vic_old = IW'(i);
    end
  end

  assign victim_idx = any_empty ? vic_empty : vic_old;

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [1:0]             lk_acc,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [2:0]             fill_perm,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr
);

  localparam int IW   = $clog2(N);
  localparam int PA_W = PPN_W + OFF_W;

  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  assign lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  logic [N-1:0]     valid_vec, lk_match, fl_match, oldest_vec;
  logic [PPN_W-1:0] hit_ppn;
  rights_t          hit_rights;
  logic [IW-1:0]    victim_idx, fill_idx, lk_idx, fl_idx, touch_idx;
  logic             wr_en, touch_en, lk_any, fl_any, allowed;

  // Index encoders for the (at most one-hot) match vectors
  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) lk_idx = IW'(i);
      if (fl_match[i]) fl_idx = IW'(i);
    end
  end

  assign lk_any   = |lk_match;
  assign fl_any   = |fl_match;
  assign fill_idx = fl_any ? fl_idx : victim_idx;
  assign wr_en    = fill_valid && !flush;
  assign allowed  = rights_allow(hit_rights, lk_acc);

  // A fill takes the recency update over a simultaneous lookup hit
  assign touch_en  = wr_en || (lk_valid && lk_any);
  assign touch_idx = wr_en ? fill_idx : lk_idx;

  tlb_store #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (flush),
    .wr_en     (wr_en),
    .wr_idx    (fill_idx),
    .wr_vpn    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .wr_rights (rights_t'(fill_perm)),
    .lk_vpn    (lk_vpn),
    .fl_vpn    (fill_vpn),
    .valid_vec (valid_vec),
    .lk_match  (lk_match),
    .fl_match  (fl_match),
    .lk_ppn    (hit_ppn),
    .lk_rights (hit_rights)
  );

  tlb_lru #(.N(N)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx),
    .oldest_vec (oldest_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any && allowed;
      rsp_fault <= lk_valid && lk_any && !allowed;
      rsp_paddr <= (lk_valid && lk_any && allowed) ? {hit_ppn, lk_off} : PA_W'(0);
    end
  end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int N    = 16,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            lk_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [N-1:0]    valid_vec,
  input logic [N-1:0]    lk_match,
  input logic [N-1:0]    oldest_vec
);

  // R2: a response follows every request by one cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R4: translation and fault are exclusive
  p_hit_fault_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_fault));

  // R6: refills never create a duplicate tag
  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R8: the recency order always names exactly one oldest entry
  p_one_oldest_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);

  // R9: flush leaves no valid entry
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  // R10: no address without a permitted hit
  p_paddr_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0));

endmodule

bind tlb_fa tlb_fa_chk #(.N(N), .PA_W(PPN_W + OFF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .lk_valid   (lk_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .valid_vec  (valid_vec),
  .lk_match   (lk_match),
  .oldest_vec (oldest_vec)
);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;

  localparam int N = 16;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int OW = 12;

  logic clk = 1'b0;
  logic rst;
  logic flush, lk_valid, fill_valid;
  logic [VW+OW-1:0] lk_vaddr;
  logic [1:0] lk_acc;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_ppn;
  logic [2:0] fill_perm;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [PW+OW-1:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  tlb_fa #(.N(N), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  // Vector: {op, vpn, ppn, perm, acc, exp_hit, exp_fault}
  // op 0 fill, 1 lookup, 2 flush
  localparam int NV = 16;
  localparam logic [48:0] VEC [NV] = '{
    {2'd1, 20'h00001, 20'h00000, 3'b000, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00001, 20'h4123B, 3'b011, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00001, 20'h4123B, 3'b000, 2'd0, 1'b1, 1'b0},
    {2'd1, 20'h00001, 20'h4123B, 3'b000, 2'd1, 1'b1, 1'b0},
    {2'd1, 20'h00001, 20'h00000, 3'b000, 2'd2, 1'b0, 1'b1},
    {2'd0, 20'h00002, 20'h10044, 3'b101, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00002, 20'h10044, 3'b000, 2'd2, 1'b1, 1'b0},
    {2'd1, 20'h00002, 20'h00000, 3'b000, 2'd1, 1'b0, 1'b1},
    {2'd1, 20'h00003, 20'h00000, 3'b000, 2'd0, 1'b0, 1'b0},
    {2'd0, 20'h00001, 20'h00777, 3'b001, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00001, 20'h00777, 3'b000, 2'd0, 1'b1, 1'b0},
    {2'd1, 20'h00001, 20'h00000, 3'b000, 2'd1, 1'b0, 1'b1},
    {2'd1, 20'h00002, 20'h10044, 3'b000, 2'd3, 1'b1, 1'b0},
    {2'd2, 20'h00000, 20'h00000, 3'b000, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00002, 20'h00000, 3'b000, 2'd0, 1'b0, 1'b0},
    {2'd1, 20'h00001, 20'h00000, 3'b000, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; flush = 0;
  endtask

  // Drive one cycle of inputs at a falling edge; results readable at the next one
  task automatic step(input logic lv, input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                      input logic [1:0] acc, input logic fv, input logic [VW-1:0] fvpn,
                      input logic [PW-1:0] fppn, input logic [2:0] fperm, input logic fl);
    lk_valid = lv; lk_vaddr = {vpn, off}; lk_acc = acc;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm; flush = fl;
    @(negedge clk);
    idle();
  endtask

  task automatic look(input logic [VW-1:0] vpn, input logic [1:0] acc, input logic [OW-1:0] off);
    step(1'b1, vpn, off, acc, 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn, input logic [2:0] perm);
    step(1'b0, '0, '0, '0, 1'b1, vpn, ppn, perm, 1'b0);
  endtask

  task automatic expect_hit(input string tag, input logic [PW-1:0] ppn, input logic [OW-1:0] off);
    chk({tag, " hit"}, {31'd0, rsp_hit}, 32'd1);
    chk({tag, " paddr"}, rsp_paddr, {ppn, off});
  endtask

  task automatic expect_miss(input string tag);
    chk({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({tag, " hit/fault"}, {30'd0, rsp_hit, rsp_fault}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] v;
    idle(); lk_vaddr = '0; lk_acc = '0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state of outputs
    chk("R1 reset outputs", {rsp_valid, rsp_hit, rsp_fault, rsp_paddr[28:0]}, 32'd0);
    chk("R1 reset paddr", rsp_paddr, 32'd0);
    @(negedge clk);
    chk("R2 no request no response", {31'd0, rsp_valid}, 32'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [OW-1:0] off;
      off = OW'((i * 12'h1A7) & 12'hFFF);
      v = VEC[i][48:1];
      case (VEC[i][48:47])
        2'd0: fill(VEC[i][46:27], VEC[i][26:7], VEC[i][6:4]);
        2'd2: step(1'b0, '0, '0, '0, 1'b0, '0, '0, '0, 1'b1);
        default: begin
          look(VEC[i][46:27], VEC[i][3:2], off);
          chk($sformatf("R2 vec%0d valid", i), {31'd0, rsp_valid}, 32'd1);
          chk($sformatf("R4 vec%0d hit", i), {31'd0, rsp_hit}, {31'd0, VEC[i][1]});
          chk($sformatf("R4 vec%0d fault", i), {31'd0, rsp_fault}, {31'd0, VEC[i][0]});
          chk($sformatf("R10 vec%0d paddr", i), rsp_paddr,
              VEC[i][1] ? {VEC[i][26:7], off} : 32'd0);
        end
      endcase
    end

    // R7: after a flush, N distinct fills all stay resident
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, '0, 1'b1);
    for (int i = 0; i < N; i++) fill(VW'(20'h100 + i), PW'(20'h200 + i), 3'b001);
    for (int i = 0; i < N; i++) begin
      look(VW'(20'h100 + i), 2'd0, 12'h040);
      expect_hit($sformatf("R7 resident %0d", i), PW'(20'h200 + i), 12'h040);
    end

    // R8: every page was just touched in order 0x100..0x10F; touch 0x100 again
    look(20'h100, 2'd0, 12'h0);
    fill(20'h1FF, 20'h2FF, 3'b001);       // displaces 0x101
    look(20'h101, 2'd0, 12'h0);
    expect_miss("R8 LRU victim evicted");
    look(20'h100, 2'd0, 12'h123);
    expect_hit("R8 touched page kept", 20'h200, 12'h123);
    // Faulting hit on 0x102 (read-only, execute requested) still refreshes it
    look(20'h102, 2'd2, 12'h0);
    chk("R8 fault on touch", {31'd0, rsp_fault}, 32'd1);
    fill(20'h1FE, 20'h2FE, 3'b001);       // displaces 0x103
    look(20'h103, 2'd0, 12'h0);
    expect_miss("R8 victim after fault touch");
    look(20'h102, 2'd0, 12'h005);
    expect_hit("R8 faulted page kept", 20'h202, 12'h005);

    // R6: refill an existing tag; all sixteen residents must remain
    fill(20'h105, 20'h999, 3'b111);
    look(20'h105, 2'd1, 12'hFFF);
    expect_hit("R6 overwrite in place", 20'h999, 12'hFFF);
    begin
      int hits;
      hits = 0;
      for (int i = 0; i < N; i++) begin
        if (i == 1 || i == 3) continue;
        look(VW'(20'h100 + i), 2'd0, 12'h0);
        hits += rsp_hit;
      end
      look(20'h1FF, 2'd0, 12'h0); hits += rsp_hit;
      look(20'h1FE, 2'd0, 12'h0); hits += rsp_hit;
      chk("R6 no entry lost", hits, N);
    end

    // R5: lookup and fill of the same page in one cycle
    step(1'b1, 20'h1FD, 12'h010, 2'd0, 1'b1, 20'h1FD, 20'h2FD, 3'b001, 1'b0);
    expect_miss("R5 same-cycle lookup sees old contents");
    look(20'h1FD, 2'd0, 12'h010);
    expect_hit("R5 fill visible next cycle", 20'h2FD, 12'h010);

    // R9: lookup during flush sees old contents; fill during flush is dropped
    step(1'b1, 20'h1FD, 12'h020, 2'd0, 1'b1, 20'h050, 20'h333, 3'b001, 1'b1);
    expect_hit("R9 lookup in flush cycle", 20'h2FD, 12'h020);
    look(20'h1FD, 2'd0, 12'h0);
    expect_miss("R9 flushed entry");
    look(20'h050, 2'd0, 12'h0);
    expect_miss("R9 fill dropped under flush");
    chk("R10 paddr zero on miss", rsp_paddr, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule